// File: doc/BRIEF.md
# Buck Converter Fault Supervisor with Low-Side Crowbar

This block watches one buck converter channel and decides when that channel may run. It receives a digitized feedback code, an overcurrent comparator flag, an enable level and a supply-good level. It reports power-good and drives enables for the high-side and low-side switch gates. Overvoltage and undervoltage are found by comparing the feedback code with thresholds set at compile time. Each threshold is expressed in codes relative to the nominal reference code: overvoltage rising at 116%, overvoltage falling at 106%, undervoltage at 86%. A reading must stay past a threshold for longer than a qualification window (2 µs by default) before it counts. The window length is computed from the clock frequency.

Any fault latches the channel off. The latch is released only when enable drops or the supply-good level drops. The first fault type is held for inspection.

A mode input chooses what the low-side switch does after a latch. In tri-state mode both gates stay off. In crowbar mode the low-side gate turns on after a qualified overvoltage reading and turns off after a qualified reading below the falling threshold. This repeats for as long as the overvoltage keeps coming back. A start-up bias enable stays on from each start until power-good first rises.

Top module: `buck_fault_guard`

## Requirements
- R1: With default parameters, an overvoltage fault latches when fbCode > 580 on 501 consecutive clock edges. 500 consecutive edges do not latch it. One sample at or below 580 restarts the count.
- R2: An undervoltage fault latches when fbCode < 430 on 501 consecutive clock edges. The count restarts in the same way as for R1.
- R3: ocFlag high at one clock edge while the channel runs latches an overcurrent fault at that edge.
- R4: While any fault is latched, pgood and hsGateEn are low and faultCause is nonzero.
- R5: A latched fault clears, and faultCause returns to 0, at the first clock edge that samples enable low or porOk low. Nothing else clears it. A clear on the same edge as a fault wins.
- R6: faultCause encodes 1 = overcurrent, 2 = overvoltage, 3 = undervoltage. It keeps the first fault until cleared. Faults that arrive on the same edge rank overcurrent, then overvoltage, then undervoltage.
- R7: With crowbarMode low, lsGateEn is low while a fault is latched.
- R8: With crowbarMode high and a fault latched, lsGateEn rises at the edge where fbCode has exceeded 580 for 501 edges. It falls at the edge where fbCode has been below 530 for 501 edges. Between 530 and 580 it holds its state.
- R9: pgood is high exactly when enable and porOk are high, no fault is latched, and 430 <= fbCode <= 580. pgood follows these inputs without a register.
- R10: startBiasEn is high after reset and after every clear. It goes low one edge after pgood is first high and stays low until the next clear.
- R11: With enable and porOk high and no fault latched, hsGateEn and lsGateEn are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fbCode | input | FB_W (10) | Digitized feedback voltage, unsigned |
| ocFlag | input | 1 | Overcurrent comparator output, high on overcurrent |
| enable | input | 1 | Channel enable level |
| porOk | input | 1 | High while input supply is above its reset threshold |
| crowbarMode | input | 1 | 1 = soft crowbar after a latch, 0 = both gates off |
| pgood | output | 1 | Power-good |
| hsGateEn | output | 1 | High-side gate enable |
| lsGateEn | output | 1 | Low-side gate enable |
| startBiasEn | output | 1 | Start-up bias current enable |
| faultCause | output | 2 | First latched fault type (see R6) |

## Verification
Two of the block's decisions can fall on the same clock edge, and the bench provokes both. In the first case, feedback is held above the rising threshold for exactly the window length. The overcurrent flag is then raised on the edge where the overvoltage qualification completes. The result is judged by faultCause reading overcurrent. In the second case, the overcurrent flag and a low enable are applied on the same edge. The result is judged by faultCause staying 0 and power-good returning once enable comes back.

// File: rtl/fs_pkg.sv
package fs_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_OC   = 2'd1,
    CAUSE_OV   = 2'd2,
    CAUSE_UV   = 2'd3
  } cause_e;

  // Qualified comparator results handed from datapath to control
  typedef struct packed {
    logic ovQual;    // above rising OV threshold for the full window
    logic uvQual;    // below UV threshold for the full window
    logic fallQual;  // below falling OV threshold for the full window
    logic inWindow;  // instantaneous UV <= fb <= OV rising
  } dpStrobes_t;

endpackage

// File: rtl/fs_qualifier.sv
module fs_qualifier #(
  parameter int QUAL_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic qualified
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);

  logic [CW-1:0] cnt;

  // Saturating run-length counter; any break in the condition restarts it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!cond) begin
      cnt <= '0;
    end else if (cnt != CW'(QUAL_CYCLES)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign qualified = cond && (cnt == CW'(QUAL_CYCLES));
endmodule

// File: rtl/fs_datapath.sv
module fs_datapath
  import fs_pkg::*;
#(
  parameter int FB_W         = 10,
  parameter int OV_RISE_CODE = 580,
  parameter int OV_FALL_CODE = 530,
  parameter int UV_CODE      = 430,
  parameter int QUAL_CYCLES  = 500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FB_W-1:0] fbCode,
  output dpStrobes_t      strobes
);
  localparam int NQ = 3;

  int unsigned fbVal;
  logic [NQ-1:0] rawCond;
  logic [NQ-1:0] qualOut;

  assign fbVal = int'(fbCode);
  // index 0: above OV rising, 1: below UV, 2: below OV falling
  assign rawCond[0] = fbVal > OV_RISE_CODE;
  assign rawCond[1] = fbVal < UV_CODE;
  assign rawCond[2] = fbVal < OV_FALL_CODE;

  for (genvar g = 0; g < NQ; g++) begin : g_qual
    fs_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .cond     (rawCond[g]),
      .qualified(qualOut[g])
    );
  end

  assign strobes.ovQual   = qualOut[0];
  assign strobes.uvQual   = qualOut[1];
  assign strobes.fallQual = qualOut[2];
  assign strobes.inWindow = !rawCond[0] && !rawCond[1];
endmodule

// File: rtl/fs_control.sv
module fs_control
  import fs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dpStrobes_t strobes,
  input  logic       ocFlag,
  input  logic       enable,
  input  logic       porOk,
  input  logic       crowbarMode,
  output logic       pgood,
  output logic       hsGateEn,
  output logic       lsGateEn,
  output logic       startBiasEn,
  output logic [1:0] faultCause
);
  logic   latched;
  logic   crowbarOn;
  logic   biasDone;
  cause_e cause;
  cause_e newCause;
  logic   clearReq;
  logic   running;

  assign clearReq = !enable || !porOk;
  assign running  = enable && porOk && !latched;

  // Same-edge priority: overcurrent, then overvoltage, then undervoltage
  always_comb begin
    if (ocFlag)              newCause = CAUSE_OC;
    else if (strobes.ovQual) newCause = CAUSE_OV;
    else if (strobes.uvQual) newCause = CAUSE_UV;
    else                     newCause = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched   <= 1'b0;
      cause     <= CAUSE_NONE;
      crowbarOn <= 1'b0;
      biasDone  <= 1'b0;
    end else if (clearReq) begin
      latched   <= 1'b0;
      cause     <= CAUSE_NONE;
      crowbarOn <= 1'b0;
      biasDone  <= 1'b0;
    end else begin
      if (!latched && newCause != CAUSE_NONE) begin
        latched <= 1'b1;
        cause   <= newCause;
      end
      if (crowbarMode && (latched || newCause != CAUSE_NONE)) begin
        if (strobes.ovQual)        crowbarOn <= 1'b1;
        else if (strobes.fallQual) crowbarOn <= 1'b0;
      end else begin
        crowbarOn <= 1'b0;
      end
      if (pgood) biasDone <= 1'b1;
    end
  end

  assign pgood       = running && strobes.inWindow;
  assign hsGateEn    = running;
  assign lsGateEn    = running || (crowbarOn && crowbarMode);
  assign startBiasEn = !biasDone;
  assign faultCause  = cause;
endmodule

// File: rtl/buck_fault_guard.sv
module buck_fault_guard
  import fs_pkg::*;
#(
  parameter int FB_W     = 10,
  parameter int REF_CODE = 500,
  parameter int CLK_MHZ  = 250,
  parameter int QUAL_NS  = 2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FB_W-1:0] fbCode,
  input  logic            ocFlag,
  input  logic            enable,
  input  logic            porOk,
  input  logic            crowbarMode,
  output logic            pgood,
  output logic            hsGateEn,
  output logic            lsGateEn,
  output logic            startBiasEn,
  output logic [1:0]      faultCause
);
  localparam int QUAL_CYCLES  = CLK_MHZ * QUAL_NS / 1000;
  localparam int OV_RISE_CODE = REF_CODE * 116 / 100;
  localparam int OV_FALL_CODE = REF_CODE * 106 / 100;
  localparam int UV_CODE      = REF_CODE * 86 / 100;

  dpStrobes_t strobes;

  fs_datapath #(
    .FB_W        (FB_W),
    .OV_RISE_CODE(OV_RISE_CODE),
    .OV_FALL_CODE(OV_FALL_CODE),
    .UV_CODE     (UV_CODE),
    .QUAL_CYCLES (QUAL_CYCLES)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .fbCode (fbCode),
    .strobes(strobes)
  );

  fs_control u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .ocFlag     (ocFlag),
    .enable     (enable),
    .porOk      (porOk),
    .crowbarMode(crowbarMode),
    .pgood      (pgood),
    .hsGateEn   (hsGateEn),
    .lsGateEn   (lsGateEn),
    .startBiasEn(startBiasEn),
    .faultCause (faultCause)
  );
endmodule

// File: rtl/fs_guard_checker.sv
module fs_guard_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ocFlag,
  input logic       enable,
  input logic       porOk,
  input logic       crowbarMode,
  input logic       pgood,
  input logic       hsGateEn,
  input logic       lsGateEn,
  input logic       startBiasEn,
  input logic [1:0] faultCause
);
  p_latched_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (faultCause != 2'd0) |-> (!pgood && !hsGateEn))
    else $error("R4: latched fault with pgood or high-side enable active");

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || !porOk) |=> (faultCause == 2'd0))
    else $error("R5: fault not cleared after enable or supply drop");

  p_first_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (faultCause != 2'd0 && enable && porOk) |=> $stable(faultCause))
    else $error("R6: fault cause overwritten while latched");

  p_tristate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!crowbarMode && faultCause != 2'd0) |-> !lsGateEn)
    else $error("R7: low-side enable on in tri-state mode while latched");

  p_oc_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ocFlag && enable && porOk && faultCause == 2'd0) |=> (faultCause == 2'd1))
    else $error("R3: overcurrent did not latch");

  p_bias_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood && enable && porOk) |=> !startBiasEn)
    else $error("R10: start bias still on after power-good");

  p_run_gates_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && porOk && faultCause == 2'd0) |-> (hsGateEn && lsGateEn))
    else $error("R11: gates not enabled while running");
endmodule

bind buck_fault_guard fs_guard_checker u_fs_guard_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .ocFlag     (ocFlag),
  .enable     (enable),
  .porOk      (porOk),
  .crowbarMode(crowbarMode),
  .pgood      (pgood),
  .hsGateEn   (hsGateEn),
  .lsGateEn   (lsGateEn),
  .startBiasEn(startBiasEn),
  .faultCause (faultCause)
);

// File: tb/buck_fault_guard_bench.sv
`timescale 1ns/1ps
module buck_fault_guard_bench;
  localparam int Q = 500;  // 2 us at 250 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] fbCode = 10'd500;
  logic       ocFlag = 1'b0;
  logic       enable = 1'b0;
  logic       porOk = 1'b1;
  logic       crowbarMode = 1'b0;
  logic       pgood, hsGateEn, lsGateEn, startBiasEn;
  logic [1:0] faultCause;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  buck_fault_guard u_buck_fault_guard (
    .clk(clk), .rst_n(rst_n), .fbCode(fbCode), .ocFlag(ocFlag),
    .enable(enable), .porOk(porOk), .crowbarMode(crowbarMode),
    .pgood(pgood), .hsGateEn(hsGateEn), .lsGateEn(lsGateEn),
    .startBiasEn(startBiasEn), .faultCause(faultCause)
  );

  typedef struct packed {
    logic [9:0]  fb;
    logic        oc, en, por, mode;
    logic [15:0] cyc;
    logic        pg, hs, ls, bias;
    logic [1:0]  cause;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{10'd500, 1'b0, 1'b1, 1'b1, 1'b0, 16'd2,      1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
    '{10'd600, 1'b0, 1'b1, 1'b1, 1'b0, 16'(Q),     1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
    '{10'd500, 1'b0, 1'b1, 1'b1, 1'b0, 16'd1,      1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
    '{10'd600, 1'b0, 1'b1, 1'b1, 1'b0, 16'(Q + 1), 1'b0, 1'b0, 1'b0, 1'b0, 2'd2},
    '{10'd500, 1'b0, 1'b1, 1'b1, 1'b0, 16'd3,      1'b0, 1'b0, 1'b0, 1'b0, 2'd2},
    '{10'd500, 1'b0, 1'b0, 1'b1, 1'b0, 16'd1,      1'b0, 1'b0, 1'b0, 1'b1, 2'd0},
    '{10'd500, 1'b0, 1'b1, 1'b1, 1'b0, 16'd2,      1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
    '{10'd420, 1'b0, 1'b1, 1'b1, 1'b0, 16'(Q + 1), 1'b0, 1'b0, 1'b0, 1'b0, 2'd3},
    '{10'd420, 1'b0, 1'b1, 1'b0, 1'b0, 16'd1,      1'b0, 1'b0, 1'b0, 1'b1, 2'd0},
    '{10'd500, 1'b0, 1'b1, 1'b1, 1'b1, 16'd2,      1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
    '{10'd500, 1'b1, 1'b1, 1'b1, 1'b1, 16'd1,      1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
    '{10'd600, 1'b0, 1'b1, 1'b1, 1'b1, 16'(Q),     1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
    '{10'd600, 1'b0, 1'b1, 1'b1, 1'b1, 16'd1,      1'b0, 1'b0, 1'b1, 1'b0, 2'd1},
    '{10'd550, 1'b0, 1'b1, 1'b1, 1'b1, 16'd10,     1'b0, 1'b0, 1'b1, 1'b0, 2'd1},
    '{10'd520, 1'b0, 1'b1, 1'b1, 1'b1, 16'(Q),     1'b0, 1'b0, 1'b1, 1'b0, 2'd1},
    '{10'd520, 1'b0, 1'b1, 1'b1, 1'b1, 16'd1,      1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
    '{10'd600, 1'b0, 1'b1, 1'b1, 1'b1, 16'(Q + 1), 1'b0, 1'b0, 1'b1, 1'b0, 2'd1},
    '{10'd600, 1'b0, 1'b0, 1'b1, 1'b1, 16'd1,      1'b0, 1'b0, 1'b0, 1'b1, 2'd0}
  };

  function automatic string rowReq(int i);
    case (i)
      0:       return "R9 R11";
      1, 2:    return "R1";
      3:       return "R1 R4 R7";
      4, 8:    return "R5";
      5, 6:    return "R5 R10";
      7:       return "R2";
      9:       return "R11";
      10:      return "R3";
      12:      return "R6 R8";
      17:      return "R5 R10";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkAll(string req, logic pg, logic hs, logic ls, logic bias, logic [1:0] cause);
    check(req, "pgood", int'(pgood), int'(pg));
    check(req, "hsGateEn", int'(hsGateEn), int'(hs));
    check(req, "lsGateEn", int'(lsGateEn), int'(ls));
    check(req, "startBiasEn", int'(startBiasEn), int'(bias));
    check(req, "faultCause", int'(faultCause), int'(cause));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    // reset state: R10 bias on, nothing latched, channel off while disabled
    checkAll("R10 reset", 1'b0, 1'b0, 1'b0, 1'b1, 2'd0);
    rst_n = 1'b1;
    step(1);
    checkAll("R10 after reset", 1'b0, 1'b0, 1'b0, 1'b1, 2'd0);

    for (int i = 0; i < NV; i++) begin
      fbCode = VECS[i].fb; ocFlag = VECS[i].oc; enable = VECS[i].en;
      porOk = VECS[i].por; crowbarMode = VECS[i].mode;
      step(int'(VECS[i].cyc));
      checkAll(rowReq(i), VECS[i].pg, VECS[i].hs, VECS[i].ls, VECS[i].bias, VECS[i].cause);
    end

    // Collision: overcurrent on the edge OV qualification completes -> R6 OC wins
    fbCode = 10'd500; ocFlag = 1'b0; enable = 1'b1; porOk = 1'b1; crowbarMode = 1'b0;
    step(2);
    checkAll("R9 restart", 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
    fbCode = 10'd600;
    step(Q);
    check("R1", "faultCause before window end", int'(faultCause), 0);
    ocFlag = 1'b1;
    step(1);
    check("R6", "priority OC over OV", int'(faultCause), 1);
    ocFlag = 1'b0;
    step(5);
    check("R6", "first cause kept under ongoing OV", int'(faultCause), 1);

    // Collision: clear and overcurrent on the same edge -> R5 clear wins
    fbCode = 10'd500; enable = 1'b0;
    step(1);
    enable = 1'b1;
    step(2);
    checkAll("R11 rerun", 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
    ocFlag = 1'b1; enable = 1'b0;
    step(1);
    check("R5", "cause with clear and OC together", int'(faultCause), 0);
    ocFlag = 1'b0; enable = 1'b1;
    step(2);
    check("R5", "pgood after clear-vs-OC edge", int'(pgood), 1);
    check("R5", "cause after clear-vs-OC edge", int'(faultCause), 0);

    // R9 window boundaries are inclusive
    fbCode = 10'd430;
    step(1);
    check("R9", "pgood at fb=430", int'(pgood), 1);
    fbCode = 10'd580;
    step(1);
    check("R9", "pgood at fb=580", int'(pgood), 1);
    fbCode = 10'd429;
    #0.5;
    check("R9", "pgood at fb=429 same cycle", int'(pgood), 0);
    fbCode = 10'd500;
    step(1);

    // R2 boundary: 500 samples below UV do not latch, one more does
    fbCode = 10'd420;
    step(Q);
    check("R2", "cause after 500 UV samples", int'(faultCause), 0);
    step(1);
    check("R2", "cause after 501 UV samples", int'(faultCause), 3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule